// File: doc/BRIEF.md
# Clock Measurement Down Counter

This block provides a free-running decrementing counter that software uses to estimate the frequency of the clock that drives it. The counter is clocked directly by the clock under measurement. It runs only while a count-enable bit in a control register is set. Software samples the count, waits a fixed interval of its own choosing, and samples the count again. The difference between the two samples, multiplied by the number of intervals in one second, gives the frequency in hertz. For a 10 ms interval the factor is 100.

The count is read through two small register windows, primary and secondary. Each window has an index port that selects an internal byte and a data port that returns the selected byte. Because the count changes while it is being read, a sample is assembled from four separate byte reads. Software therefore has to retry whenever the high part of the count moved during those reads, or whenever the count appears to have increased.

The high part is exposed in the secondary window starting at bit 15. That byte overlaps the top bit of the primary high byte, so the two secondary bytes hold 15 significant bits between them. Reset is asynchronous on assertion and is released synchronously through a two-stage synchronizer.

Top module: `clkmeas_dcnt`

## Requirements
- R1: After reset the counter holds all ones, the control register reads 0x00, and both index ports read 0x00.
- R2: While control bit 6 is 1, the counter decreases by exactly one on every clock edge. Counting starts on the first edge after the edge that writes the bit.
- R3: While control bit 6 is 0, the counter keeps its value.
- R4: The control register sits at index 0x01 of the primary window, reached with `acc_win`=0. Writes to it store all 8 bits, and a read returns the last value written.
- R5: In the primary window, a data-port read at index 0x20 returns count bits 7:0, and a read at index 0x21 returns count bits 15:8.
- R6: In the secondary window (`acc_win`=1), a data-port read at index 0x20 returns count bits 22:15. A read at index 0x21 returns count bits 29:23 in its low 7 bits, with bit 7 always 0. Count bits above the counter width read as 0.
- R7: When the counter is 0 and counting is enabled, the next edge loads all ones.
- R8: Data-port writes to the count indices are ignored. In the secondary window, index 0x01 is not a control register: writes to it have no effect, and reads of it return 0x00.
- R9: A write with `acc_port`=0 loads the index of the selected window only. A read with `acc_port`=0 returns that index.
- R10: A data-port read of any index that is not mapped returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock under measurement; also clocks register access |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Write strobe for one cycle |
| acc_win | input | 1 | Window select: 0 primary, 1 secondary |
| acc_port | input | 1 | Port select: 0 index port, 1 data port |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the current window and port (combinational) |

## Verification
A control write that clears the enable bit can land on the same edge at which the counter wraps from zero to all ones. The bench lets a reduced 16-bit instance run down until its count reaches 1. It then writes the control index on that edge and the disabling value on the edge where the count is 0. The result is accepted only if the counter wrapped to all ones on that edge and then held that value. This shows that the enable in force before the write governs the edge on which the write happens.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned NUM_WIN  = 2;
  localparam logic [7:0]  IDX_CTRL = 8'h01;
  localparam logic [7:0]  IDX_LO   = 8'h20;
  localparam logic [7:0]  IDX_HI   = 8'h21;
  localparam int unsigned EN_BIT   = 6;
endpackage

// File: rtl/cm_rst_sync.sv
module cm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/cm_byte_reg.sv
module cm_byte_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb begin
    d = q;
    if (wr_en) begin
      d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= d;
    end
  end
endmodule

// File: rtl/cm_down_cnt.sv
module cm_down_cnt #(
  parameter int unsigned CNT_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] STEP     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             at_zero;

  always_comb begin
    at_zero = (cnt == '0);
    if (at_zero) begin
      cnt_d = ALL_ONES;
    end else begin
      cnt_d = cnt - STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= ALL_ONES;
    end else if (en) begin
      cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/cm_rd_mux.sv
module cm_rd_mux #(
  parameter int unsigned CNT_W   = 30,
  parameter int unsigned HI_BASE = 15
) (
  input  logic                                win_sel,
  input  logic                                port_sel,
  input  logic [cm_pkg::NUM_WIN-1:0][cm_pkg::DW-1:0] idx,
  input  logic [cm_pkg::DW-1:0]               ctrl,
  input  logic [CNT_W-1:0]                    cnt,
  output logic [cm_pkg::DW-1:0]               rdata
);
  import cm_pkg::*;

  localparam int unsigned EXT_W = HI_BASE + 2 * DW;

  logic [EXT_W-1:0]                ext;
  logic [NUM_WIN-1:0][DW-1:0]      win_data;

  always_comb begin
    ext = '0;
    ext[CNT_W-1:0] = cnt;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int unsigned BASE = (w == 0) ? 0 : HI_BASE;
    always_comb begin
      case (idx[w])
        IDX_LO:   win_data[w] = ext[BASE +: DW];
        IDX_HI:   win_data[w] = ext[BASE + DW +: DW];
        IDX_CTRL: win_data[w] = (w == 0) ? ctrl : '0;
        default:  win_data[w] = '0;
      endcase
    end
  end

  always_comb begin
    if (port_sel) begin
      rdata = win_data[win_sel];
    end else begin
      rdata = idx[win_sel];
    end
  end
endmodule

// File: rtl/clkmeas_dcnt.sv
module clkmeas_dcnt #(
  parameter int unsigned CNT_W   = 30,
  parameter int unsigned HI_BASE = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_wr,
  input  logic       acc_win,
  input  logic       acc_port,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata
);
  import cm_pkg::*;

  logic                       rst_q_n;
  logic [NUM_WIN-1:0][DW-1:0] idx_q;
  logic [NUM_WIN-1:0]         idx_wr;
  logic                       ctrl_wr;
  logic [DW-1:0]              ctrl_q;
  logic                       cnt_en;
  logic [CNT_W-1:0]           cnt_q;

  cm_rst_sync rst_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_idx
    always_comb begin
      idx_wr[w] = acc_wr && !acc_port && (acc_win == w[0]);
    end

    cm_byte_reg #(.W(DW)) idx_reg_i (
      .clk   (clk),
      .rst_n (rst_q_n),
      .wr_en (idx_wr[w]),
      .wdata (acc_wdata),
      .q     (idx_q[w])
    );
  end

  always_comb begin
    ctrl_wr = acc_wr && acc_port && !acc_win && (idx_q[0] == IDX_CTRL);
  end

  cm_byte_reg #(.W(DW)) ctrl_reg_i (
    .clk   (clk),
    .rst_n (rst_q_n),
    .wr_en (ctrl_wr),
    .wdata (acc_wdata),
    .q     (ctrl_q)
  );

  assign cnt_en = ctrl_q[EN_BIT];

  cm_down_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_q_n),
    .en    (cnt_en),
    .cnt   (cnt_q)
  );

  cm_rd_mux #(.CNT_W(CNT_W), .HI_BASE(HI_BASE)) rd_mux_i (
    .win_sel  (acc_win),
    .port_sel (acc_port),
    .idx      (idx_q),
    .ctrl     (ctrl_q),
    .cnt      (cnt_q),
    .rdata    (acc_rdata)
  );
endmodule

// File: rtl/cm_dcnt_chk.sv
module cm_dcnt_chk #(
  parameter int unsigned CNT_W = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [CNT_W-1:0] cnt,
  input logic             acc_wr,
  input logic             acc_win,
  input logic             acc_port,
  input logic [7:0]       sec_idx,
  input logic [7:0]       acc_rdata
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != '0) |=> cnt == $past(cnt) - STEP);

  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));

  a_r7_wrap_to_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == '0) |=> (&cnt));

  a_r6_top_byte_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_win && acc_port && sec_idx == 8'h21) |-> !acc_rdata[7]);

  a_r8_sec_not_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_win) |=> $stable(en));

  a_r8_sec_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_win && acc_port && sec_idx == 8'h01) |-> acc_rdata == 8'h00);
endmodule

bind clkmeas_dcnt cm_dcnt_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .en        (cnt_en),
  .cnt       (cnt_q),
  .acc_wr    (acc_wr),
  .acc_win   (acc_win),
  .acc_port  (acc_port),
  .sec_idx   (idx_q[1]),
  .acc_rdata (acc_rdata)
);

// File: tb/clkmeas_dcnt_tb_top.sv
module clkmeas_dcnt_tb_top;
  logic       clk;
  logic       rst_n;
  logic       acc_wr;
  logic       acc_win;
  logic       acc_port;
  logic [7:0] acc_wdata;
  logic [7:0] rd30;
  logic [7:0] rd16;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [29:0] m30;
  logic [15:0] m16;
  logic        m_en;
  logic [7:0]  m_pidx;
  logic [7:0]  r30, r16;

  clkmeas_dcnt dut_i (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_win(acc_win),
    .acc_port(acc_port), .acc_wdata(acc_wdata), .acc_rdata(rd30));

  clkmeas_dcnt #(.CNT_W(16)) dut16_i (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_win(acc_win),
    .acc_port(acc_port), .acc_wdata(acc_wdata), .acc_rdata(rd16));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Spec model: enable from control writes, decrement and wrap per edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m30 <= '1; m16 <= '1; m_en <= 1'b0; m_pidx <= 8'h00;
    end else begin
      if (m_en) begin
        m30 <= (m30 == 0) ? 30'h3FFFFFFF : m30 - 30'd1;
        m16 <= (m16 == 0) ? 16'hFFFF : m16 - 16'd1;
      end
      if (acc_wr && !acc_win && !acc_port) m_pidx <= acc_wdata;
      if (acc_wr && !acc_win && acc_port && m_pidx == 8'h01) m_en <= acc_wdata[6];
    end
  end

  function automatic logic [7:0] expb(input logic win, input logic [7:0] idx, input logic [29:0] m);
    logic [37:0] e;
    e = {8'h00, m};
    if (idx == 8'h20) return win ? e[22:15] : e[7:0];
    if (idx == 8'h21) return win ? e[30:23] : e[15:8];
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic win, input logic port, input logic [7:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_win = win; acc_port = port; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd(input logic win, input logic [7:0] idx);
    wr(win, 1'b0, idx);
    acc_win = win; acc_port = 1'b1;
    #1;
    r30 = rd30; r16 = rd16;
  endtask

  task automatic chk_all(input string req);
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k < 2; k++) begin
        logic [7:0] ix;
        ix = (k == 0) ? 8'h20 : 8'h21;
        rd(w[0], ix);
        chk(req, r30, expb(w[0], ix, m30));
        chk(req, r16, expb(w[0], ix, {14'd0, m16}));
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; acc_wr = 1'b0; acc_win = 1'b0; acc_port = 1'b0; acc_wdata = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    acc_port = 1'b0; acc_win = 1'b0; #1;
    chk("R1 pri index", rd30, 8'h00);
    acc_win = 1'b1; #1;
    chk("R1 sec index", rd30, 8'h00);
    rd(0, 8'h01);
    chk("R1 ctrl", r30, 8'h00);
    rd(0, 8'h20); chk("R1 R5 lo", r30, 8'hFF); chk("R1 lo16", r16, 8'hFF);
    rd(0, 8'h21); chk("R1 R5 hi", r30, 8'hFF);
    rd(1, 8'h20); chk("R1 R6 sec lo", r30, 8'hFF); chk("R6 sec lo16", r16, 8'h01);
    rd(1, 8'h21); chk("R1 R6 sec hi", r30, 8'h7F); chk("R6 sec hi16", r16, 8'h00);

    // R3: disabled at reset, no movement
    repeat (20) @(negedge clk);
    rd(0, 8'h20); chk("R3 idle", r30, 8'hFF);

    // R2 R4: enable and sweep reads at several distances
    wr(0, 0, 8'h01); wr(0, 1, 8'h55);
    rd(0, 8'h01); chk("R4 ctrl 55", r30, 8'h55);
    for (int k = 0; k < 8; k++) begin
      repeat (13 + k * 29) @(negedge clk);
      chk_all("R2 R5 R6 running");
    end

    // R3 R4: freeze with other bits kept
    wr(0, 0, 8'h01); wr(0, 1, 8'h15);
    rd(0, 8'h01); chk("R4 ctrl 15", r30, 8'h15);
    repeat (50) @(negedge clk);
    chk_all("R3 frozen");

    // R8: writes to count indices and secondary 0x01 have no effect
    wr(0, 0, 8'h20); wr(0, 1, 8'h00);
    wr(0, 0, 8'h21); wr(0, 1, 8'h00);
    wr(1, 0, 8'h20); wr(1, 1, 8'h00);
    wr(1, 0, 8'h01); wr(1, 1, 8'h40);
    repeat (20) @(negedge clk);
    rd(1, 8'h01); chk("R8 sec 01 reads 0", r30, 8'h00);
    chk_all("R8 count unchanged");

    // R9: per-window index
    wr(0, 0, 8'h21); wr(1, 0, 8'h20);
    acc_port = 1'b0; acc_win = 1'b0; #1; chk("R9 pri idx", rd30, 8'h21);
    acc_win = 1'b1; #1; chk("R9 sec idx", rd30, 8'h20);
    acc_port = 1'b1; acc_win = 1'b0; #1; chk("R9 pri data", rd30, expb(0, 8'h21, m30));
    acc_win = 1'b1; #1; chk("R9 sec data", rd30, expb(1, 8'h20, m30));

    // R10: unmapped sweep
    for (int i = 0; i < 256; i++) begin
      for (int w = 0; w < 2; w++) begin
        if (i != 8'h20 && i != 8'h21 && !(w == 0 && i == 8'h01)) begin
          rd(w[0], i[7:0]);
          chk("R10 unmapped", r30, 8'h00);
          chk("R10 unmapped16", r16, 8'h00);
        end
      end
    end

    // R7: wrap of the 16-bit instance
    wr(0, 0, 8'h01); wr(0, 1, 8'h40);
    wr(0, 0, 8'h20);
    acc_win = 1'b0; acc_port = 1'b1;
    while (m16 != 16'd4) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #1;
      chk("R7 wrap lo", rd16, m16[7:0]);
      chk("R2 run lo", rd30, m30[7:0]);
    end

    // Disable write on the wrap edge
    while (m16 != 16'd1) @(negedge clk);
    acc_wr = 1'b1; acc_port = 1'b0; acc_wdata = 8'h01;
    @(negedge clk);
    acc_port = 1'b1; acc_wdata = 8'h00;
    @(negedge clk);
    acc_wr = 1'b0;
    repeat (10) @(negedge clk);
    rd(0, 8'h20); chk("R7 wrap on disable lo", r16, 8'hFF);
    rd(0, 8'h21); chk("R7 wrap on disable hi", r16, 8'hFF);
    repeat (10) @(negedge clk);
    rd(0, 8'h20); chk("R3 held after wrap", r16, 8'hFF);
    chk_all("R2 R3 final");

    finish_run();
  end
endmodule